// File: doc/BRIEF.md
# Sound Stream FIFO with Sticky Full Override

This block buffers 16-bit audio words on their way from a host processor to a sound processor. The host pushes words with a write strobe. The sound processor pulls them with a read strobe and sees each word on a registered data output one cycle later. The storage is a circular buffer of 512 entries with separate read and write pointers and an occupancy counter.

An 8-bit status word reports three occupancy thresholds at fixed bit positions: empty, half-full and full. The host can also raise a sticky override with a force-full strobe. While the override is set, the status reports full and never empty, whatever the real occupancy. The override does not stop data from moving. A synchronous clear strobe empties the buffer and drops the override. The empty indication is also driven out as a level, so that an interrupt controller can use it as a request source.

Top module: `stream_fifo`

## Requirements
- R1: Once reset is released, the status word is 0x08 (only the empty bit set), `rd_data` is 0 and `empty_lvl` is 1.
- R2: Words come out in the order they were accepted. A word read by a strobe in cycle N appears on `rd_data` after the clock edge that ends cycle N, and `rd_data` holds that value until the next accepted read strobe or an empty read.
- R3: A write strobe while the occupancy equals the depth (512) is dropped, even when a read happens in the same cycle. The dropped word is never delivered.
- R4: A read strobe while the occupancy is zero loads 0 into `rd_data` and leaves the occupancy and pointers unchanged.
- R5: Status bit 3 (empty) is 1 only when the occupancy is zero and the override is clear.
- R6: Status bit 4 (half) is 1 when the occupancy is 256 or more.
- R7: Status bit 5 (full) is 1 when the occupancy is 512 or the override is set.
- R8: A `force_full` strobe sets the override. The override stays set until a clear, and writes and reads keep working while it is set.
- R9: A `fifo_clear` strobe empties the buffer and clears the override. Write, read and force strobes in the same cycle are ignored, and `rd_data` keeps its value.
- R10: A read and a write in the same cycle on a buffer that is neither empty nor full leave the occupancy unchanged.
- R11: `empty_lvl` always equals status bit 3.
- R12: Status bits 0 to 2, 6 and 7 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 16 | Host write word |
| force_full | input | 1 | Sets the sticky full override |
| fifo_clear | input | 1 | Synchronous buffer clear |
| rd_en | input | 1 | Consumer read strobe |
| rd_data | output | 16 | Registered read word |
| status | output | 8 | Bit 3 empty, bit 4 half, bit 5 full, other bits 0 |
| empty_lvl | output | 1 | Empty level for the interrupt logic |

## Verification
The bench fills the buffer one word at a time across the 255/256 half threshold and up to 512. A compare that is off by one moves the half bit by one word. It then writes to the full buffer, both alone and together with a read. A design that lets the extra word in corrupts the data order and delivers a word that should have been lost. Reads of an empty buffer are checked for a zero result, because a design that moves its pointer there would later return stale data. The bench also checks that the override keeps the buffer reporting full while data still flows, that a clear drops the override, and that a clear in the same cycle as other strobes wins over them. A design that handles any of these wrongly shows a wrong status or sends the sound processor the wrong words.

// File: rtl/stream_fifo_pkg.sv
// Package: shared constants for the sound stream FIFO.
// Holds the default geometry and the fixed status bit positions
// that the register file decodes.
package stream_fifo_pkg;
    localparam int DEF_WIDTH = 16;
    localparam int DEF_DEPTH = 512;
    localparam int STAT_BITS = 8;
    localparam int BIT_EMPTY = 3;
    localparam int BIT_HALF  = 4;
    localparam int BIT_FULL  = 5;

    // Decoded occupancy thresholds before they are placed in the status word
    typedef struct packed {
        logic full;
        logic half;
        logic empty;
    } fifo_flags_t;
endpackage

// File: rtl/stream_fifo_ram.sv
// Module: stream_fifo_ram
// Simple dual-port storage with a registered read port.
// Assumes: at most one write and one read per cycle. The control logic
// guarantees the read address never equals a location written in the
// same cycle while that location holds no data.
module stream_fifo_ram #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic             rzero,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Purpose: store an accepted word
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Purpose: register the read word, or zero for an empty read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mem[raddr];
        end else if (rzero) begin
            rdata <= '0;
        end
    end
endmodule

// File: rtl/stream_fifo_ctrl.sv
// Module: stream_fifo_ctrl
// Pointer, occupancy and sticky override control.
// Assumes: strobes are one clock wide and synchronous. A clear wins over
// every other strobe in its cycle. A write is dropped only when the
// occupancy equals the depth, judged before any read in the same cycle.
module stream_fifo_ctrl #(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic          rd_req,
    input  logic          force_req,
    input  logic          clr_req,
    output logic          push,
    output logic          pop,
    output logic          pop_zero,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic [CW-1:0] occ,
    output logic          ovr
);
    localparam logic [CW-1:0] OCC_MAX  = CW'(DEPTH);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

    logic at_max;
    logic at_zero;

    // Purpose: decide which strobes take effect this cycle
    always_comb begin
        at_max   = (occ == OCC_MAX);
        at_zero  = (occ == '0);
        push     = wr_req && !clr_req && !at_max;
        pop      = rd_req && !clr_req && !at_zero;
        pop_zero = rd_req && !clr_req && at_zero;
    end

    // Purpose: advance the write pointer with wrap
    always_ff @(posedge clk) begin
        if (!rst_n || clr_req) begin
            wptr <= '0;
        end else if (push) begin
            wptr <= (wptr == PTR_LAST) ? '0 : wptr + 1'b1;
        end
    end

    // Purpose: advance the read pointer with wrap
    always_ff @(posedge clk) begin
        if (!rst_n || clr_req) begin
            rptr <= '0;
        end else if (pop) begin
            rptr <= (rptr == PTR_LAST) ? '0 : rptr + 1'b1;
        end
    end

    // Purpose: track occupancy; push and pop together cancel
    always_ff @(posedge clk) begin
        if (!rst_n || clr_req) begin
            occ <= '0;
        end else begin
            case ({push, pop})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    // Purpose: hold the sticky full override until a clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr_req) begin
            ovr <= 1'b0;
        end else if (force_req) begin
            ovr <= 1'b1;
        end
    end
endmodule

// File: rtl/stream_fifo_flags.sv
// Module: stream_fifo_flags
// Turns occupancy and the override into the three threshold flags and
// places them at their fixed bit positions in the status word.
// Assumes: occupancy never exceeds the depth.
module stream_fifo_flags
    import stream_fifo_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic [CW-1:0]        occ,
    input  logic                 ovr,
    output logic [STAT_BITS-1:0] status
);
    localparam logic [CW-1:0] OCC_MAX  = CW'(DEPTH);
    localparam logic [CW-1:0] OCC_HALF = CW'(DEPTH / 2);

    fifo_flags_t flg;

    // Purpose: compute the threshold flags with the override applied
    always_comb begin
        flg.empty = (occ == '0) && !ovr;
        flg.half  = (occ >= OCC_HALF);
        flg.full  = (occ == OCC_MAX) || ovr;
    end

    // Purpose: pack the flags into the status word, other bits zero
    always_comb begin
        status            = '0;
        status[BIT_EMPTY] = flg.empty;
        status[BIT_HALF]  = flg.half;
        status[BIT_FULL]  = flg.full;
    end
endmodule

// File: rtl/stream_fifo.sv
// Module: stream_fifo (top)
// Sound stream FIFO: the host writes, the sound processor reads, the status
// word holds the threshold flags, and the empty level goes to interrupt logic.
// Assumes: a single clock domain and a synchronous active-low reset.
module stream_fifo
    import stream_fifo_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH,
    parameter int DEPTH = DEF_DEPTH
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [WIDTH-1:0]     wr_data,
    input  logic                 force_full,
    input  logic                 fifo_clear,
    input  logic                 rd_en,
    output logic [WIDTH-1:0]     rd_data,
    output logic [STAT_BITS-1:0] status,
    output logic                 empty_lvl
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic          push;
    logic          pop;
    logic          pop_zero;
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic [CW-1:0] occ;
    logic          ovr;

    stream_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (wr_en),
        .rd_req    (rd_en),
        .force_req (force_full),
        .clr_req   (fifo_clear),
        .push      (push),
        .pop       (pop),
        .pop_zero  (pop_zero),
        .wptr      (wptr),
        .rptr      (rptr),
        .occ       (occ),
        .ovr       (ovr)
    );

    stream_fifo_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (push),
        .waddr (wptr),
        .wdata (wr_data),
        .re    (pop),
        .rzero (pop_zero),
        .raddr (rptr),
        .rdata (rd_data)
    );

    stream_fifo_flags #(.DEPTH(DEPTH)) u_flags (
        .occ    (occ),
        .ovr    (ovr),
        .status (status)
    );

    // Purpose: drive the empty level for the interrupt logic
    always_comb begin
        empty_lvl = status[BIT_EMPTY];
    end
endmodule

// File: rtl/stream_fifo_chk.sv
// Module: stream_fifo_chk
// Port-level checker for stream_fifo, attached with bind.
// Assumes: reset is held for at least two clock edges.
module stream_fifo_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             force_full,
    input logic             fifo_clear,
    input logic             rd_en,
    input logic [WIDTH-1:0] rd_data,
    input logic [7:0]       status,
    input logic             empty_lvl
);
    // R11: the empty level follows status bit 3
    a_r11_level_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        empty_lvl == status[3]);

    // R5, R7: empty and full are never reported together
    a_r5_empty_not_full: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[3] && status[5]));

    // R8: after a force strobe without a clear, full is reported
    a_r8_force_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (force_full && !fifo_clear) |=> status[5]);

    // R9: a clear leaves exactly the empty flag
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clear |=> (status == 8'h08));

    // R4: a read of an empty buffer returns zero
    a_r4_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && status[3] && !fifo_clear) |=> (rd_data == '0));

    // R6: the half flag can only rise after a write
    a_r6_half_rises_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[4]) |-> $past(wr_en));

    // R10: a read and a write together in mid range keep the status stable
    a_r10_balanced_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && !fifo_clear && !force_full && !status[3] && !status[5])
        |=> $stable(status));
endmodule

bind stream_fifo stream_fifo_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .force_full (force_full),
    .fifo_clear (fifo_clear),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .status     (status),
    .empty_lvl  (empty_lvl)
);

// File: tb/stream_fifo_bench.sv
`timescale 1ns/1ps
module stream_fifo_bench;
    localparam int DEPTH = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        force_full = 1'b0;
    logic        fifo_clear = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic [7:0]  status;
    logic        empty_lvl;

    int n_cmp = 0;
    int n_bad = 0;

    logic [15:0] mq[$];
    bit          m_ovr = 1'b0;
    logic [15:0] m_rd = '0;
    logic [15:0] wseq = 16'h1000;

    always #2.5 clk = ~clk;

    stream_fifo u_stream_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .force_full(force_full), .fifo_clear(fifo_clear), .rd_en(rd_en),
        .rd_data(rd_data), .status(status), .empty_lvl(empty_lvl)
    );

    function automatic logic [7:0] exp_status(int cnt, bit ovr);
        logic [7:0] s = '0;
        s[3] = (cnt == 0) && !ovr;
        s[4] = (cnt >= DEPTH / 2);
        s[5] = (cnt == DEPTH) || ovr;
        return s;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk({tag, " status"}, 32'(status), 32'(exp_status(mq.size(), m_ovr)));
        chk("R11 empty level", 32'(empty_lvl), 32'(exp_status(mq.size(), m_ovr) >> 3) & 1);
        chk({tag, " rd_data"}, 32'(rd_data), 32'(m_rd));
    endtask

    // One cycle: drive at the falling edge, update the model, check at the next falling edge
    task automatic step(string tag, bit w, bit r, bit ff, bit c);
        bit was_full;
        wr_en = w; wr_data = wseq; rd_en = r; force_full = ff; fifo_clear = c;
        if (c) begin
            mq.delete();
            m_ovr = 1'b0;
        end else begin
            was_full = (mq.size() == DEPTH);
            if (r) m_rd = (mq.size() > 0) ? mq.pop_front() : 16'h0000;
            if (w && !was_full) mq.push_back(wseq);
            if (ff) m_ovr = 1'b1;
        end
        wseq = wseq + 16'h0101;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; force_full = 1'b0; fifo_clear = 1'b0;
        check_all(tag);
    endtask

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: state after reset
        chk("R1 status", 32'(status), 32'h08);
        chk("R1 rd_data", 32'(rd_data), 32'h0);
        chk("R1 empty level", 32'(empty_lvl), 32'h1);

        // R4: read of an empty buffer
        step("R4 empty read", 1'b0, 1'b1, 1'b0, 1'b0);
        // R4: simultaneous write and read on an empty buffer
        step("R4 empty read with write", 1'b1, 1'b1, 1'b0, 1'b0);
        step("R2 single read", 1'b0, 1'b1, 1'b0, 1'b0);

        // R6, R7: fill across the half threshold up to the depth
        for (int i = 0; i < DEPTH; i++) step("R6 R7 fill", 1'b1, 1'b0, 1'b0, 1'b0);
        // R3: writes at full depth are dropped, alone and with a read
        step("R3 drop write", 1'b1, 1'b0, 1'b0, 1'b0);
        step("R3 drop with read", 1'b1, 1'b1, 1'b0, 1'b0);
        // R10: balanced traffic in mid range
        for (int i = 0; i < 20; i++) step("R10 balanced", 1'b1, 1'b1, 1'b0, 1'b0);
        // R2: drain in order
        while (mq.size() > 0) step("R2 drain", 1'b0, 1'b1, 1'b0, 1'b0);
        step("R4 read after drain", 1'b0, 1'b1, 1'b0, 1'b0);

        // R8: override on an empty buffer, data still moves
        step("R8 force", 1'b0, 1'b0, 1'b1, 1'b0);
        step("R8 write under force", 1'b1, 1'b0, 1'b0, 1'b0);
        step("R8 read under force", 1'b0, 1'b1, 1'b0, 1'b0);
        step("R8 sticky", 1'b0, 1'b0, 1'b0, 1'b0);
        // R9: clear wins over simultaneous strobes
        step("R9 fill", 1'b1, 1'b0, 1'b0, 1'b0);
        step("R9 clear", 1'b1, 1'b1, 1'b1, 1'b1);
        step("R9 after clear", 1'b0, 1'b1, 1'b0, 1'b0);

        // Random traffic with phases biased to fill and to drain
        for (int ph = 0; ph < 8; ph++) begin
            int wp = (ph % 2 == 0) ? 80 : 25;
            for (int k = 0; k < 400; k++) begin
                bit w  = ($urandom % 100) < wp;
                bit r  = ($urandom % 100) < (105 - wp);
                bit ff = ($urandom % 1000) < 3;
                bit c  = ($urandom % 1000) < 2;
                step("R2 R5 R6 R7 random", w, r, ff, c);
            end
        end
        // R12 is covered by the full-width status compare in every step
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule